// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Decoder

This block is a synthesizable behavioural model of a word-wide, one-time-programmable memory together with the control decoding that sits in front of it. Each cycle it looks at three active-low strobes and two qualifier flags. The strobes are chip select, output gate and program strobe. The flags say that the programming supply is raised and that the identification voltage is present on the address line. From these it chooses one of seven operating modes. The mode is reported on a small code output. The 16-bit data output is qualified by an enable flag, which stands in for a high-impedance bus.

Cells start at one. A programming pulse can only clear bits: the stored word becomes the old word ANDed with the incoming data. The write is committed on the clock edge that first sees the program strobe high again after a low pulse. Only the all-ones erase input can bring bits back to one. A fixed identification pair can be read out without touching the array.

Top module: `otp_mode_decoder`

## Requirements
- R1: With chip select low, output gate low, program strobe high and both flags low, `mode` is 0 (read), `dout_en` is 1 and `dout` is the word at `addr`.
- R2: With chip select high and the supply flag low, `mode` is 5 (standby) and `dout_en` is 0, whatever the output gate does.
- R3: With chip select low and output gate high, when no program pulse is active, `mode` is 1 (output off) and `dout_en` is 0.
- R4: With the supply flag high, chip select low and program strobe low, `mode` is 2 (program) and `dout_en` is 0. At the first clock edge that sees the strobe high again, with chip select still low and the supply flag still high, the word at `addr` is written using the `din` present at that edge.
- R5: With the supply flag high, chip select low, output gate low and program strobe high, `mode` is 3 (verify), `dout_en` is 1 and `dout` is the word at `addr`.
- R6: With the supply flag high and chip select high, `mode` is 4 (inhibit) and `dout_en` is 0. A program pulse given in this state changes no word.
- R7: With the identification flag high, the supply flag low, chip select and output gate low and program strobe high, `mode` is 6 (signature). `dout` is 16'h0020 when `addr[0]` is 0 and 16'h001C when `addr[0]` is 1, whatever the array holds.
- R8: A write stores old AND `din`. A bit that holds 0 stays 0 even when a later write presents a 1 for it.
- R9: `erase` high at a clock edge sets every word to 16'hFFFF. Erase wins over a write at the same edge.
- R10: A program strobe pulse given while the supply flag is low changes no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the strobe history |
| erase | input | 1 | Set whole array to all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply is raised |
| id_hi | input | 1 | Identification voltage present |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Data to program |
| dout | output | 16 | Read, verify or signature data |
| dout_en | output | 1 | Data output is driven |
| mode | output | 3 | Current operating mode code |

## Verification
A wrong mode decode is visible on `mode` and `dout_en` in the same cycle the strobes settle. A wrong write shows up on the first later read or verify of that word. The bench reads back after every write, so a write that fails to land, lands at the wrong edge or can set a bit is caught one access after the pulse. A bad erase is caught by reading every word of the array back. A write that slips through in inhibit mode, or with the supply low, is caught by a verify read of the targeted word.

// File: rtl/otp_mode_decoder.sv
module otp_mode_decoder #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [2:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] M_READ = 3'd0, M_OFF = 3'd1, M_PROG = 3'd2, M_VERIFY = 3'd3,
                         M_INHIBIT = 3'd4, M_STANDBY = 3'd5, M_SIG = 3'd6;
  localparam logic [DATA_W-1:0] SIG_LO = DATA_W'(16'h0020);
  localparam logic [DATA_W-1:0] SIG_HI = DATA_W'(16'h001C);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pgm_q;
  logic              wr;

  always_comb begin
    if (ce_n)                               mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    else if (vpp_hi && !pgm_n)              mode = M_PROG;
    else if (oe_n || !pgm_n)                mode = M_OFF;
    else if (vpp_hi)                        mode = M_VERIFY;
    else if (id_hi)                         mode = M_SIG;
    else                                    mode = M_READ;
  end

  assign dout_en = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_SIG);
  assign dout    = (mode == M_SIG) ? (addr[0] ? SIG_HI : SIG_LO) : mem[addr];
  assign wr      = !pgm_q && pgm_n && !ce_n && vpp_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> !dout_en);
  assert_sig_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SIG) |-> (dout[DATA_W-1:8] == '0));
  assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !erase) |=> ((mem[$past(addr)] & ~$past(mem[addr])) == '0));
  assert_erase_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (mem[$past(addr)] == '1));
  assert_no_write_low_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && !erase) |=> (mem[$past(addr)] == $past(mem[addr])));
endmodule

// File: tb/sim_otp_mode_decoder.sv
module sim_otp_mode_decoder;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, erase = 0, ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, id_hi = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0, dout;
  logic dout_en;
  logic [2:0] mode;
  logic [15:0] model [DEPTH];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  otp_mode_decoder #(.ADDR_W(AW), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hi(id_hi), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .mode(mode));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input logic c, input logic o, input logic p, input logic v,
                       input logic i, input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hi = i; addr = a;
    #2;
  endtask

  task automatic pulse(input logic c, input logic v, input logic [AW-1:0] a, input logic [15:0] d);
    setup(c, 1, 1, v, 0, a);
    din = d;
    @(negedge clk); pgm_n = 0; #2;
    if (!c && v) chk("R4 mode during pulse", {29'd0, mode}, 32'd2);
    if (!c && v) chk("R4 output off during pulse", {31'd0, dout_en}, 32'd0);
    @(negedge clk); pgm_n = 1;
    @(negedge clk);
    if (!c && v) model[a] = model[a] & d;
  endtask

  task automatic verify_word(input string req, input logic [AW-1:0] a);
    setup(0, 0, 1, 1, 0, a);
    chk(req, {29'd0, mode, dout}, {29'd3, model[a]});
  endtask

  task automatic t_reset_standby();
    chk("R2 reset standby mode", {29'd0, mode}, 32'd5);
    setup(1, 0, 1, 0, 0, 0);
    chk("R2 standby with gate low", {28'd0, mode, dout_en}, {28'd0, 3'd5, 1'b0});
  endtask

  task automatic t_erase_all();
    @(negedge clk); erase = 1; @(negedge clk); erase = 0;
    for (int k = 0; k < DEPTH; k++) model[k] = 16'hFFFF;
    for (int k = 0; k < DEPTH; k++) begin
      setup(0, 0, 1, 0, 0, AW'(k));
      chk("R9 erased word reads ones", {15'd0, dout_en, dout}, {15'd0, 1'b1, 16'hFFFF});
    end
  endtask

  task automatic t_modes();
    setup(0, 1, 1, 0, 0, 3);
    chk("R3 output off", {28'd0, mode, dout_en}, {28'd0, 3'd1, 1'b0});
    setup(1, 0, 1, 1, 0, 3);
    chk("R6 inhibit", {28'd0, mode, dout_en}, {28'd0, 3'd4, 1'b0});
  endtask

  task automatic t_program();
    pulse(0, 1, 5, 16'hA5F0);
    setup(0, 0, 1, 0, 0, 5);
    chk("R1 read programmed", {28'd0, mode, dout_en, dout}, {12'd0, 3'd0, 1'b1, 16'hA5F0});
    verify_word("R5 verify programmed", 5);
    pulse(0, 1, 5, 16'hFF0F);
    verify_word("R8 second write ANDs", 5);
    chk("R8 value", {16'd0, model[5]}, 32'h0000A500);
    pulse(0, 1, 5, 16'hFFFF);
    verify_word("R8 ones do not restore", 5);
    pulse(0, 1, 6, 16'h1234);
    verify_word("R4 neighbour word", 6);
    verify_word("R4 other word untouched", 5);
  endtask

  task automatic t_blocked_writes();
    pulse(1, 1, 9, 16'h0000);
    verify_word("R6 inhibit pulse no write", 9);
    pulse(0, 0, 9, 16'h0000);
    verify_word("R10 low supply pulse no write", 9);
  endtask

  task automatic t_signature();
    setup(0, 0, 1, 0, 1, 4);
    chk("R7 manufacturer id", {15'd0, dout_en, dout}, {15'd0, 1'b1, 16'h0020});
    chk("R7 sig mode", {29'd0, mode}, 32'd6);
    setup(0, 0, 1, 0, 1, 5);
    chk("R7 device id", {15'd0, dout_en, dout}, {15'd0, 1'b1, 16'h001C});
  endtask

  task automatic t_erase_vs_write();
    setup(0, 1, 1, 1, 0, 2);
    din = 16'h0000;
    @(negedge clk); pgm_n = 0;
    @(negedge clk); pgm_n = 1; erase = 1;
    @(negedge clk); erase = 0;
    for (int k = 0; k < DEPTH; k++) model[k] = 16'hFFFF;
    verify_word("R9 erase beats write", 2);
    verify_word("R9 erase restores programmed word", 5);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    t_reset_standby();
    t_erase_all();
    t_modes();
    t_program();
    t_blocked_writes();
    t_signature();
    t_erase_vs_write();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule